// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block is a cycle-based controller model of a flash memory's hardware reset and ready/busy behaviour. A low level on the device reset pin is accepted only once it has been held long enough. Program and erase operations run for a parameterised number of cycles. While one of them runs, the block drives an open-drain style busy indication, and a running erase can be suspended and resumed.

When a reset is accepted during a program or erase (suspended or not), the recovery after the pin is released is longer. The busy indication stays asserted for the whole reset, and a sticky flag records that data was corrupted. A reset taken from read or standby uses a short recovery, and the busy line stays released. A supply-lockout input blocks every command while it is asserted. A system integrator uses the outputs to pace the commands sent to the modelled device.

Top module: `frb_seq`

## Requirements
- R1: A reset is taken on the clock edge that samples `rst_pin_n` low for the `LOW_MIN`-th consecutive time, and `st` shows the reset code after that edge. A shorter low run leaves state, timing and `aborted` unchanged. A running operation completes on its original schedule.
- R2: A reset taken from read (code 0) or standby (code 1) ends in read after `REC_SHORT` edges, counting the first edge that samples the pin high. `rb_pd_en` stays 0 throughout.
- R3: A reset taken from program (2), erase (3) or erase-suspended (4) holds `rb_pd_en` at 1 from the edge that takes it until recovery ends. Recovery lasts `REC_LONG` edges after the pin rises.
- R4: A reset taken from a busy mode ends in the same cycle in which `rb_pd_en` falls, `st` returns to read and `ready` rises.
- R5: A reset taken from program, erase or erase-suspended sets `aborted`. The flag then stays set until the system reset `rst_n`.
- R6: A program request in read or standby starts program (code 2) for exactly `PGM_CYCLES` cycles. An erase request starts erase (code 3) for exactly `ERS_CYCLES` cycles. Each then returns to read. When both requests arrive together, program is started.
- R7: During program or erase, new program and erase requests are ignored, and so is a suspend during program. The running operation's length is unchanged. In erase-suspended, program and erase requests are ignored.
- R8: A suspend request during erase enters erase-suspended (code 4) and freezes the progress. A resume request returns to erase for the remaining cycles, so the erase cycles in total equal `ERS_CYCLES`.
- R9: `rb_pd_en` is 0 in read, standby and erase-suspended. `stby_req` high in read enters standby, and `stby_req` low in standby returns to read. `ready` is 1 in read and standby.
- R10: After `rst_n`, `st` is read (0), `ready` is 1, `rb_pd_en` is 0 and `aborted` is 0. Every reset recovery returns to read.
- R11: While `lockout` is 1 or `rst_pin_n` is 0, program, erase, suspend and resume requests have no effect.
- R12: If a reset is taken on the same edge on which a program or erase would complete, the reset wins. It is treated as a busy-mode reset, with long recovery and `aborted` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset (power-up) |
| rst_pin_n | input | 1 | Device hardware reset pin, active low |
| prog_req | input | 1 | Program start request |
| erase_req | input | 1 | Erase start request |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| stby_req | input | 1 | Standby request (level) |
| lockout | input | 1 | Supply lockout, blocks commands |
| rb_pd_en | output | 1 | Pull-down enable for ready/busy, 1 = busy |
| ready | output | 1 | Ready for a new operation |
| aborted | output | 1 | Sticky: an operation was cut short by reset |
| st | output | 3 | State: 0 read, 1 standby, 2 program, 3 erase, 4 erase-suspended, 5 reset |

## Verification
Reset acceptance and the completion of an operation can fall on the same clock edge. The bench starts a program and times the reset pin's low run so that its `LOW_MIN`-th low sample lands on the program's final edge. It then expects the reset state, `rb_pd_en` held at 1, `aborted` set and the long recovery. Suspend and lockout arriving together are also provoked, and the erase is expected to finish on its original schedule.

// File: rtl/frb_pkg.sv
// Shared types for the flash reset / ready-busy sequencer.
package frb_pkg;
    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_STBY  = 3'd1,
        ST_PROG  = 3'd2,
        ST_ERASE = 3'd3,
        ST_SUSP  = 3'd4,
        ST_RST   = 3'd5
    } frb_state_e;
endpackage

// File: rtl/frb_pulse_qual.sv
// Reset pin qualifier: counts consecutive low samples of the reset pin and
// emits a one-cycle take pulse on the LOW_MIN-th one. The count saturates,
// so one low run gives one pulse. Assumes LOW_MIN >= 1.
module frb_pulse_qual #(
    parameter int LOW_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic take
);
    localparam int PW = $clog2(LOW_MIN + 1);

    logic [PW-1:0] low_cnt;

    // Take fires combinationally on the qualifying low sample.
    assign take = !pin_n && (low_cnt == PW'(LOW_MIN - 1));

    // Count the low run; clear it on any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != PW'(LOW_MIN)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frb_ctr.sv
// Plain cycle counter with clear priority over increment. Assumes the
// caller never increments past the range of W bits.
module frb_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Clear or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frb_seq.sv
// Flash reset and ready/busy sequencer. Models the device mode (read,
// standby, program, erase, erase-suspended, reset), the recovery after a
// hardware reset (short from idle, long from a busy mode), a sticky abort
// flag and the open-drain busy enable. Assumes every cycle count >= 2
// except REC_SHORT >= 1, and REC_SHORT <= REC_LONG.
module frb_seq
    import frb_pkg::*;
#(
    parameter int LOW_MIN    = 4,
    parameter int REC_SHORT  = 3,
    parameter int REC_LONG   = 12,
    parameter int PGM_CYCLES = 6,
    parameter int ERS_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_pin_n,
    input  logic       prog_req,
    input  logic       erase_req,
    input  logic       susp_req,
    input  logic       resume_req,
    input  logic       stby_req,
    input  logic       lockout,
    output logic       rb_pd_en,
    output logic       ready,
    output logic       aborted,
    output logic [2:0] st
);
    localparam int OP_MAX = (ERS_CYCLES > PGM_CYCLES) ? ERS_CYCLES : PGM_CYCLES;
    localparam int OPW    = $clog2(OP_MAX);
    localparam int RCW    = $clog2(REC_LONG);

    frb_state_e    state_q, state_d;
    logic          long_q, long_d;
    logic          abort_set;
    logic          take;
    logic          cmd_ok;
    logic          op_clr, op_inc, op_last;
    logic [OPW-1:0] op_cnt;
    logic          rec_run, rec_last;
    logic [RCW-1:0] rec_cnt;

    frb_pulse_qual #(.LOW_MIN(LOW_MIN)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rst_pin_n),
        .take  (take)
    );

    frb_ctr #(.W(OPW)) u_op_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (op_clr),
        .inc   (op_inc),
        .cnt   (op_cnt)
    );

    frb_ctr #(.W(RCW)) u_rec_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rec_run),
        .inc   (rec_run && !rec_last),
        .cnt   (rec_cnt)
    );

    // Commands need a released reset pin and no supply lockout.
    assign cmd_ok = rst_pin_n && !lockout;

    // Final cycle of the running program or erase.
    assign op_last = ((state_q == ST_PROG)  && (op_cnt == OPW'(PGM_CYCLES - 1))) ||
                     ((state_q == ST_ERASE) && (op_cnt == OPW'(ERS_CYCLES - 1)));

    // Recovery runs only in reset state with the pin released.
    assign rec_run  = (state_q == ST_RST) && rst_pin_n;
    assign rec_last = rec_run &&
                      (rec_cnt == (long_q ? RCW'(REC_LONG - 1) : RCW'(REC_SHORT - 1)));

    // Next-state logic; an accepted reset overrides every other event.
    always_comb begin
        state_d   = state_q;
        long_d    = long_q;
        abort_set = 1'b0;
        op_clr    = 1'b0;
        op_inc    = 1'b0;
        if (take) begin
            state_d = ST_RST;
            if (state_q != ST_RST) begin
                long_d    = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                            (state_q == ST_SUSP);
                abort_set = long_d;
            end
        end else begin
            unique case (state_q)
                ST_READ, ST_STBY: begin
                    if (cmd_ok && prog_req) begin
                        state_d = ST_PROG;
                        op_clr  = 1'b1;
                    end else if (cmd_ok && erase_req) begin
                        state_d = ST_ERASE;
                        op_clr  = 1'b1;
                    end else if ((state_q == ST_READ) && stby_req) begin
                        state_d = ST_STBY;
                    end else if ((state_q == ST_STBY) && !stby_req) begin
                        state_d = ST_READ;
                    end
                end
                ST_PROG: begin
                    if (op_last) state_d = ST_READ;
                    else         op_inc  = 1'b1;
                end
                ST_ERASE: begin
                    if (op_last) begin
                        state_d = ST_READ;
                    end else begin
                        op_inc = 1'b1;
                        if (cmd_ok && susp_req) state_d = ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (cmd_ok && resume_req) state_d = ST_ERASE;
                end
                ST_RST: begin
                    if (rec_last) begin
                        state_d = ST_READ;
                        long_d  = 1'b0;
                    end
                end
                default: state_d = ST_READ;
            endcase
        end
    end

    // State, recovery kind and sticky abort registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            long_q  <= 1'b0;
            aborted <= 1'b0;
        end else begin
            state_q <= state_d;
            long_q  <= long_d;
            if (abort_set) aborted <= 1'b1;
        end
    end

    // Outputs decoded from the registered state.
    assign rb_pd_en = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                      ((state_q == ST_RST) && long_q);
    assign ready    = (state_q == ST_READ) || (state_q == ST_STBY);
    assign st       = state_q;
endmodule

// File: rtl/frb_seq_chk.sv
// Property checker for frb_seq, attached by bind below.
module frb_seq_chk
    import frb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rst_pin_n,
    input logic       lockout,
    input logic [2:0] st,
    input logic       rb_pd_en,
    input logic       ready,
    input logic       aborted
);
    AST_RESET_NEEDS_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RST && $past(st) != ST_RST) |-> !$past(rst_pin_n)); // R1

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |=> aborted); // R5

    AST_ABORT_ONLY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> (st == ST_RST) &&
        ($past(st) == ST_PROG || $past(st) == ST_ERASE || $past(st) == ST_SUSP)); // R5

    AST_PROG_NO_NEW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> (st == ST_PROG || st == ST_READ || st == ST_RST)); // R7

    AST_ERASE_NO_NEW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |=> (st == ST_ERASE || st == ST_READ ||
                              st == ST_SUSP || st == ST_RST)); // R7

    AST_LOCKOUT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && (st == ST_READ || st == ST_STBY)) |=>
        (st == ST_READ || st == ST_STBY || st == ST_RST)); // R11

    AST_RB_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ || st == ST_STBY || st == ST_SUSP) |-> !rb_pd_en); // R9

    AST_RESET_EXITS_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RST) |=> (st == ST_RST || st == ST_READ)); // R10

    AST_RB_FALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rb_pd_en) && $past(st) == ST_RST) |-> ready); // R4
endmodule

bind frb_seq frb_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_pin_n (rst_pin_n),
    .lockout   (lockout),
    .st        (st),
    .rb_pd_en  (rb_pd_en),
    .ready     (ready),
    .aborted   (aborted)
);

// File: tb/tb_frb_seq.sv
`timescale 1ns/1ps
// Directed bench for frb_seq: one task per scenario, each self-checking.
module tb_frb_seq;
    localparam int LOW_MIN    = 4;
    localparam int REC_SHORT  = 3;
    localparam int REC_LONG   = 12;
    localparam int PGM_CYCLES = 6;
    localparam int ERS_CYCLES = 16;

    localparam int S_READ = 0, S_STBY = 1, S_PROG = 2, S_ERASE = 3, S_SUSP = 4, S_RST = 5;

    logic clk = 1'b0;
    logic rst_n, rst_pin_n, prog_req, erase_req, susp_req, resume_req, stby_req, lockout;
    logic rb_pd_en, ready, aborted;
    logic [2:0] st;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    frb_seq #(
        .LOW_MIN(LOW_MIN), .REC_SHORT(REC_SHORT), .REC_LONG(REC_LONG),
        .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .prog_req(prog_req),
        .erase_req(erase_req), .susp_req(susp_req), .resume_req(resume_req),
        .stby_req(stby_req), .lockout(lockout), .rb_pd_en(rb_pd_en),
        .ready(ready), .aborted(aborted), .st(st)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts further cycles spent in state s.
    task automatic wait_leave(input int s, inout int n);
        while (int'(st) == s && n < 1000) begin
            tick();
            if (int'(st) == s) n++;
        end
    endtask

    task automatic por();
        rst_n = 1'b0; rst_pin_n = 1'b1; prog_req = 1'b0; erase_req = 1'b0;
        susp_req = 1'b0; resume_req = 1'b0; stby_req = 1'b0; lockout = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_powerup();
        por();
        chk("R10 state", int'(st), S_READ);
        chk("R10 ready", int'(ready), 1);
        chk("R10 rb", int'(rb_pd_en), 0);
        chk("R10 aborted", int'(aborted), 0);
    endtask

    task automatic t_prog_prio();
        int n;
        por();
        prog_req = 1'b1; erase_req = 1'b1;
        tick();
        prog_req = 1'b0; erase_req = 1'b0;
        chk("R6 prio state", int'(st), S_PROG);
        chk("R6 rb busy", int'(rb_pd_en), 1);
        n = 1;
        wait_leave(S_PROG, n);
        chk("R6 prog length", n, PGM_CYCLES);
        chk("R6 back to read", int'(st), S_READ);
    endtask

    task automatic t_busy_reject();
        int n;
        por();
        prog_req = 1'b1;
        tick();
        erase_req = 1'b1; susp_req = 1'b1;
        tick();
        prog_req = 1'b0; erase_req = 1'b0; susp_req = 1'b0;
        chk("R7 prog holds", int'(st), S_PROG);
        n = 2;
        wait_leave(S_PROG, n);
        chk("R7 prog length", n, PGM_CYCLES);
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0; prog_req = 1'b1;
        tick();
        prog_req = 1'b0;
        chk("R7 erase holds", int'(st), S_ERASE);
        n = 2;
        wait_leave(S_ERASE, n);
        chk("R7 erase length", n, ERS_CYCLES);
    endtask

    task automatic t_suspend();
        int n;
        por();
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0;
        repeat (4) tick();
        susp_req = 1'b1;
        tick();
        susp_req = 1'b0;
        chk("R8 suspended", int'(st), S_SUSP);
        chk("R9 rb released in suspend", int'(rb_pd_en), 0);
        repeat (3) tick();
        erase_req = 1'b1; prog_req = 1'b1;
        tick();
        erase_req = 1'b0; prog_req = 1'b0;
        chk("R7 requests ignored in suspend", int'(st), S_SUSP);
        resume_req = 1'b1;
        tick();
        resume_req = 1'b0;
        chk("R8 resumed", int'(st), S_ERASE);
        n = 1;
        wait_leave(S_ERASE, n);
        chk("R8 remaining length", n, ERS_CYCLES - 5);
        chk("R8 back to read", int'(st), S_READ);
    endtask

    task automatic t_standby();
        por();
        stby_req = 1'b1;
        tick();
        chk("R9 standby", int'(st), S_STBY);
        chk("R9 rb in standby", int'(rb_pd_en), 0);
        chk("R9 ready in standby", int'(ready), 1);
        stby_req = 1'b0;
        tick();
        chk("R9 leave standby", int'(st), S_READ);
    endtask

    task automatic t_lockout();
        int n;
        por();
        lockout = 1'b1; prog_req = 1'b1;
        tick();
        chk("R11 prog locked", int'(st), S_READ);
        prog_req = 1'b0; erase_req = 1'b1;
        tick();
        chk("R11 erase locked", int'(st), S_READ);
        lockout = 1'b0;
        tick();
        erase_req = 1'b0; lockout = 1'b1; susp_req = 1'b1;
        tick();
        lockout = 1'b0; susp_req = 1'b0;
        chk("R11 suspend locked", int'(st), S_ERASE);
        n = 2;
        wait_leave(S_ERASE, n);
        chk("R11 erase length", n, ERS_CYCLES);
        rst_pin_n = 1'b0; prog_req = 1'b1;
        tick(); tick();
        chk("R11 pin low blocks", int'(st), S_READ);
        rst_pin_n = 1'b1; prog_req = 1'b0;
        tick();
        chk("R11 still read", int'(st), S_READ);
    endtask

    task automatic t_short_pulse();
        int n;
        por();
        prog_req = 1'b1;
        tick();
        prog_req = 1'b0;
        n = 1;
        rst_pin_n = 1'b0;
        repeat (LOW_MIN - 1) begin
            tick();
            if (int'(st) == S_PROG) n++;
        end
        rst_pin_n = 1'b1;
        wait_leave(S_PROG, n);
        chk("R1 short pulse prog length", n, PGM_CYCLES);
        chk("R1 no abort", int'(aborted), 0);
        rst_pin_n = 1'b0;
        repeat (LOW_MIN - 1) tick();
        rst_pin_n = 1'b1;
        tick();
        chk("R1 short pulse in read", int'(st), S_READ);
    endtask

    task automatic t_reset_read();
        int bad;
        por();
        rst_pin_n = 1'b0;
        repeat (LOW_MIN - 1) tick();
        chk("R1 not yet taken", int'(st), S_READ);
        tick();
        chk("R1 taken", int'(st), S_RST);
        chk("R2 not ready", int'(ready), 0);
        tick(); tick();
        rst_pin_n = 1'b1;
        bad = 0;
        for (int i = 0; i < REC_SHORT - 1; i++) begin
            tick();
            if (int'(st) != S_RST || rb_pd_en) bad++;
        end
        chk("R2 recovery window", bad, 0);
        tick();
        chk("R2 ready after short recovery", int'(st), S_READ);
        chk("R2 rb never asserted", int'(rb_pd_en), 0);
        chk("R2 no abort", int'(aborted), 0);
    endtask

    task automatic t_reset_busy();
        int bad;
        por();
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0;
        repeat (3) tick();
        rst_pin_n = 1'b0;
        repeat (LOW_MIN) tick();
        chk("R3 reset state", int'(st), S_RST);
        chk("R3 rb held", int'(rb_pd_en), 1);
        chk("R5 aborted set", int'(aborted), 1);
        repeat (3) tick();
        rst_pin_n = 1'b1;
        bad = 0;
        for (int i = 0; i < REC_LONG - 1; i++) begin
            tick();
            if (int'(st) != S_RST || !rb_pd_en) bad++;
        end
        chk("R3 long recovery window", bad, 0);
        tick();
        chk("R4 read after long recovery", int'(st), S_READ);
        chk("R4 rb released", int'(rb_pd_en), 0);
        chk("R4 ready", int'(ready), 1);
        repeat (5) tick();
        chk("R5 aborted sticky", int'(aborted), 1);
    endtask

    task automatic t_coincide();
        int bad;
        por();
        prog_req = 1'b1;
        tick();
        prog_req = 1'b0;
        repeat (PGM_CYCLES - LOW_MIN) tick();
        rst_pin_n = 1'b0;
        repeat (LOW_MIN) tick();
        chk("R12 reset wins", int'(st), S_RST);
        chk("R12 rb held", int'(rb_pd_en), 1);
        chk("R12 aborted", int'(aborted), 1);
        rst_pin_n = 1'b1;
        bad = 0;
        for (int i = 0; i < REC_LONG - 1; i++) begin
            tick();
            if (int'(st) != S_RST) bad++;
        end
        chk("R12 long recovery", bad, 0);
        tick();
        chk("R12 read after recovery", int'(st), S_READ);
    endtask

    initial begin
        t_powerup();
        t_prog_prio();
        t_busy_reject();
        t_suspend();
        t_standby();
        t_lockout();
        t_short_pulse();
        t_reset_read();
        t_reset_busy();
        t_coincide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule